// File: doc/BRIEF.md
# VGA Frame Timer with Scanline Address Sequencing

This block produces the horizontal and vertical sync pulses for a raster display. It also supplies, for every scanline in the active picture, the base address in a framebuffer from which a separate pixel streamer should fetch that line. A free-running horizontal position counter sets the sync pulse and the active pixel window, and it marks the end of each line. A four-state vertical sequencer counts lines and steps through the regions of the frame. A line pointer shows each stored row on a fixed number of consecutive scanlines. It wraps at the end of the buffer and starts every frame from a host-chosen row, which allows vertical scrolling.

The vertical sequencer has the states RG_BACK (back porch), RG_VIS (active picture), RG_FRONT (front porch) and RG_SYNC (vertical sync). Each transition is checked only on a line tick, against the line count after it has been incremented:
- RG_BACK to RG_VIS when the count reaches `VIS_START`. This is the "enter picture" transition, and it loads the line pointer.
- RG_VIS to RG_FRONT when the count reaches `VFP_START`. This is the "leave picture" transition.
- RG_FRONT to RG_SYNC when the count reaches `VS_START`. This is the "arm sync low" transition.
- RG_SYNC to RG_BACK when the count reaches `VS_END`. This is the "frame wrap" transition, which clears the count to zero and arms sync high.

A level change requested by the sync transitions appears on the vsync pin one line later, at a line boundary. All outputs come from registers.

Top module: `vga_line_timer`

## Requirements
- R1: After reset is released, the horizontal position steps once per clock through 0 to H_TOTAL-1 (H_TOTAL = H_ACTIVE+H_FP+H_SYNC+H_BP) and then repeats. Every output is registered, so in a given cycle it reflects the position and state of the previous cycle.
- R2: `hsync_n_o` is low while the position lies in the range [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC). It is high at every other position.
- R3: On the last position of each line, the line count is incremented. The region then moves, in the fixed cycle back porch, visible, front porch, sync, back porch, when the new count reaches VIS_START, VFP_START, VS_START or VS_END respectively. Reaching VS_END also sets the count to 0.
- R4: `line_visible_o` is high exactly while the sequencer is in the visible region.
- R5: `pix_en_o` is high only when the sequencer is in the visible region and the horizontal position is below H_ACTIVE. It is low at all other times.
- R6: On entry to the visible region, `line_addr_o` becomes the value of `start_addr_i` sampled at the entering line tick. A change to `start_addr_i` at any other time has no effect until the next entry.
- R7: On each later visible line whose line count is a multiple of REPEAT, the address increases by ROW_LEN. On every other line the previous address is kept, and outside the visible region the address holds its last value.
- R8: If an increased address is equal to or greater than SCREEN (ROW_LEN*ROWS), SCREEN is subtracted from it.
- R9: `vsync_n_o` goes low at the first line boundary after the line on which the count reached VS_START. It goes high again at the first line boundary after the line on which the count reached VS_END.
- R10: While `rst_ni` is low, `hsync_n_o` and `vsync_n_o` are 1, `line_visible_o` and `pix_en_o` are 0 and `line_addr_o` is 0. The sequencer leaves reset in the back porch region with a line count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_addr_i | input | AW | Framebuffer address of the first row shown in a frame; must be below SCREEN |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| line_visible_o | output | 1 | High during visible-region lines |
| pix_en_o | output | 1 | Pixel streaming window |
| line_addr_o | output | AW | Framebuffer base address of the current line |

## Verification
Two events can fall in the same cycle. A host write of `start_addr_i` can land on the line tick that enters the picture, and a row advance can coincide with the wrap past the end of the buffer. The bench steers directed writes onto the exact entering tick, including the top address SCREEN-1, so the first advance must wrap. Random writes at other times, including the middle of the picture, must leave the shown address unchanged until the next frame. Every output is compared cycle by cycle against a reference model that the bench builds from the requirements. The bench uses a repeat factor of 3 and a buffer with few rows, so that wraps happen often.

// File: rtl/vga_lt_pkg.sv
package vga_lt_pkg;

    typedef enum logic [1:0] {
        RG_BACK  = 2'd0,
        RG_VIS   = 2'd1,
        RG_FRONT = 2'd2,
        RG_SYNC  = 2'd3
    } region_e;

    function automatic region_e region_after(input region_e r);
        unique case (r)
            RG_BACK:  return RG_VIS;
            RG_VIS:   return RG_FRONT;
            RG_FRONT: return RG_SYNC;
            default:  return RG_BACK;
        endcase
    endfunction

endpackage

// File: rtl/vga_lt_hcount.sv
module vga_lt_hcount #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o,
    output logic h_active_o,
    output logic hsync_n_o
);

    localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int HS_START = H_ACTIVE + H_FP;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int HW       = $clog2(H_TOTAL);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

    logic [HW-1:0] h_q;
    logic          in_sync;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            h_q <= '0;
        end else if (tick_o) begin
            h_q <= '0;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign tick_o     = (h_q == H_LAST);
    assign h_active_o = (int'(h_q) < H_ACTIVE);
    assign in_sync    = (int'(h_q) >= HS_START) && (int'(h_q) < HS_END);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hsync_n_o <= 1'b1;
        end else begin
            hsync_n_o <= !in_sync;
        end
    end

    AST_HSYNC_FALL_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hsync_n_o) |-> (int'($past(h_q)) == HS_START)); // R2

    AST_HSYNC_RISE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hsync_n_o) |-> (int'($past(h_q)) == HS_END)); // R2

endmodule

// File: rtl/vga_lt_vseq.sv
module vga_lt_vseq
    import vga_lt_pkg::*;
#(
    parameter int VIS_START = 33,
    parameter int VFP_START = 513,
    parameter int VS_START  = 523,
    parameter int VS_END    = 525,
    parameter int REPEAT    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic in_vis_o,
    output logic load_o,
    output logic adv_o,
    output logic visible_o,
    output logic vsync_n_o
);

    localparam int LW = $clog2(VS_END + 1);
    localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1;
    localparam logic [RW-1:0] REP_LAST = RW'(REPEAT - 1);

    region_e       state_q, state_d;
    logic [LW-1:0] line_q, line_d, line_inc;
    logic [RW-1:0] rep_q, rep_d, rep_inc;
    logic          req_q, req_d;
    logic          lvl_q;

    // State register process
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RG_BACK;
            line_q  <= '0;
            rep_q   <= '0;
            req_q   <= 1'b1;
            lvl_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            rep_q   <= rep_d;
            req_q   <= req_d;
            if (tick_i) begin
                lvl_q <= req_q;
            end
        end
    end

    assign line_inc = line_q + 1'b1;
    assign rep_inc  = (rep_q == REP_LAST) ? '0 : rep_q + 1'b1;

    // Transition process
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        rep_d   = rep_q;
        req_d   = req_q;
        load_o  = 1'b0;
        adv_o   = 1'b0;
        if (tick_i) begin
            line_d = line_inc;
            rep_d  = rep_inc;
            unique case (state_q)
                RG_BACK: begin
                    if (int'(line_inc) >= VIS_START) begin
                        state_d = RG_VIS;
                        load_o  = 1'b1;
                    end
                end
                RG_VIS: begin
                    if (int'(line_inc) >= VFP_START) begin
                        state_d = RG_FRONT;
                    end else if (rep_inc == '0) begin
                        adv_o = 1'b1;
                    end
                end
                RG_FRONT: begin
                    if (int'(line_inc) >= VS_START) begin
                        state_d = RG_SYNC;
                        req_d   = 1'b0;
                    end
                end
                RG_SYNC: begin
                    if (int'(line_inc) >= VS_END) begin
                        state_d = RG_BACK;
                        line_d  = '0;
                        rep_d   = '0;
                        req_d   = 1'b1;
                    end
                end
                default: begin
                    state_d = RG_BACK;
                end
            endcase
        end
    end

    assign in_vis_o = (state_q == RG_VIS);

    // Output process
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            visible_o <= 1'b0;
            vsync_n_o <= 1'b1;
        end else begin
            visible_o <= (state_q == RG_VIS);
            vsync_n_o <= lvl_q;
        end
    end

    AST_REGION_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != $past(state_q)) |-> (state_q == region_after($past(state_q)))); // R3

    AST_REGION_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != $past(state_q)) |-> $past(tick_i)); // R3

    AST_VSYNC_AT_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q != $past(lvl_q)) |-> $past(tick_i)); // R9

    AST_LINE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(line_q) < VS_END); // R3

endmodule

// File: rtl/vga_lt_lineaddr.sv
module vga_lt_lineaddr #(
    parameter int ROW_LEN = 160,
    parameter int SCREEN  = 38400,
    parameter int AW      = $clog2(SCREEN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [AW-1:0] start_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW:0] ROW_W    = (AW+1)'(ROW_LEN);
    localparam logic [AW:0] SCREEN_W = (AW+1)'(SCREEN);

    logic [AW-1:0] ptr_q;
    logic [AW:0]   sum;
    logic [AW-1:0] next_ptr;

    assign sum      = {1'b0, ptr_q} + ROW_W;
    assign next_ptr = (sum >= SCREEN_W) ? AW'(sum - SCREEN_W) : AW'(sum);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= start_i;
        end else if (adv_i) begin
            ptr_q <= next_ptr;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            addr_o <= '0;
        end else begin
            addr_o <= ptr_q;
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !load_i && (int'(ptr_q) < SCREEN)) |=> (int'(ptr_q) < SCREEN)); // R8

    AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !load_i) |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/vga_line_timer.sv
module vga_line_timer #(
    parameter int H_ACTIVE  = 640,
    parameter int H_FP      = 16,
    parameter int H_SYNC    = 96,
    parameter int H_BP      = 48,
    parameter int VIS_START = 33,
    parameter int VFP_START = 513,
    parameter int VS_START  = 523,
    parameter int VS_END    = 525,
    parameter int REPEAT    = 2,
    parameter int ROW_LEN   = 160,
    parameter int ROWS      = 240,
    localparam int SCREEN   = ROW_LEN * ROWS,
    localparam int AW       = $clog2(SCREEN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] start_addr_i,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic          line_visible_o,
    output logic          pix_en_o,
    output logic [AW-1:0] line_addr_o
);

    logic tick;
    logic h_active;
    logic in_vis;
    logic load;
    logic adv;

    vga_lt_hcount #(
        .H_ACTIVE (H_ACTIVE),
        .H_FP     (H_FP),
        .H_SYNC   (H_SYNC),
        .H_BP     (H_BP)
    ) hcount_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_o     (tick),
        .h_active_o (h_active),
        .hsync_n_o  (hsync_n_o)
    );

    vga_lt_vseq #(
        .VIS_START (VIS_START),
        .VFP_START (VFP_START),
        .VS_START  (VS_START),
        .VS_END    (VS_END),
        .REPEAT    (REPEAT)
    ) vseq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .in_vis_o  (in_vis),
        .load_o    (load),
        .adv_o     (adv),
        .visible_o (line_visible_o),
        .vsync_n_o (vsync_n_o)
    );

    vga_lt_lineaddr #(
        .ROW_LEN (ROW_LEN),
        .SCREEN  (SCREEN),
        .AW      (AW)
    ) lineaddr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .adv_i   (adv),
        .start_i (start_addr_i),
        .addr_o  (line_addr_o)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_en_o <= 1'b0;
        end else begin
            pix_en_o <= in_vis && h_active;
        end
    end

    AST_PIX_IN_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_en_o |-> line_visible_o); // R5

    AST_PIX_OFF_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hsync_n_o |-> !pix_en_o); // R5

endmodule

// File: tb/vga_line_timer_tb_top.sv
`timescale 1ns/1ps
module vga_line_timer_tb_top;

    localparam int HA = 16, HFP = 2, HS = 4, HBP = 3;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VIS = 3, VFP = 15, VSS = 17, VSE = 19;
    localparam int REP = 3, ROWL = 5, ROWN = 3;
    localparam int SCR = ROWL * ROWN;
    localparam int AW = $clog2(SCR);
    localparam int RUN_CYCLES = 60 * HT * VSE;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          hsync_n, vsync_n, vis, pe;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vga_line_timer #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .VIS_START(VIS), .VFP_START(VFP), .VS_START(VSS), .VS_END(VSE),
        .REPEAT(REP), .ROW_LEN(ROWL), .ROWS(ROWN)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .start_addr_i(start_addr),
        .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .line_visible_o(vis),
        .pix_en_o(pe), .line_addr_o(addr)
    );

    // Reference model built from the requirements (0 back, 1 vis, 2 front, 3 sync)
    int m_h, m_line, m_rep, m_reg, m_ptr, m_req, m_lvl;
    int e_hs, e_vs, e_vis, e_pe, e_addr;
    string m_atag = "R6";

    always @(posedge clk) begin
        if (!rst_ni) begin
            m_h = 0; m_line = 0; m_rep = 0; m_reg = 0; m_ptr = 0; m_req = 1; m_lvl = 1;
            e_hs = 1; e_vs = 1; e_vis = 0; e_pe = 0; e_addr = 0;
        end else begin
            e_hs   = (m_h >= HA + HFP && m_h < HA + HFP + HS) ? 0 : 1;
            e_vis  = (m_reg == 1) ? 1 : 0;
            e_pe   = (m_reg == 1 && m_h < HA) ? 1 : 0;
            e_addr = m_ptr;
            e_vs   = m_lvl;
            if (m_h == HT - 1) begin
                int nl;
                m_h = 0;
                m_lvl = m_req;
                nl = m_line + 1;
                m_rep = (m_rep == REP - 1) ? 0 : m_rep + 1;
                case (m_reg)
                    0: if (nl >= VIS) begin m_reg = 1; m_ptr = int'(start_addr); m_atag = "R6"; end
                    1: if (nl >= VFP) m_reg = 2;
                       else if (m_rep == 0) begin
                           m_ptr = m_ptr + ROWL;
                           m_atag = "R7";
                           if (m_ptr >= SCR) begin m_ptr = m_ptr - SCR; m_atag = "R8"; end
                       end
                    2: if (nl >= VSS) begin m_reg = 3; m_req = 0; end
                    default: if (nl >= VSE) begin m_reg = 0; nl = 0; m_rep = 0; m_req = 1; end
                endcase
                m_line = nl;
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails <= 30) $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Output comparison away from the active edge
    always @(negedge clk) begin
        if (!rst_ni) begin
            check(hsync_n == 1'b1, "R10 hsync", int'(hsync_n), 1);
            check(vsync_n == 1'b1, "R10 vsync", int'(vsync_n), 1);
            check(vis == 1'b0, "R10 visible", int'(vis), 0);
            check(pe == 1'b0, "R10 pix_en", int'(pe), 0);
            check(addr == '0, "R10 addr", int'(addr), 0);
        end else begin
            check(int'(hsync_n) == e_hs, "R1 R2 hsync", int'(hsync_n), e_hs);
            check(int'(vsync_n) == e_vs, "R9 vsync", int'(vsync_n), e_vs);
            check(int'(vis) == e_vis, "R3 R4 visible", int'(vis), e_vis);
            check(int'(pe) == e_pe, "R5 pix_en", int'(pe), e_pe);
            check(int'(addr) == e_addr, {m_atag, " line_addr"}, int'(addr), e_addr);
        end
    end

    task automatic write_on_entry(input int value);
        // wait until the next rising edge is the tick that enters the picture
        do @(negedge clk); while (!(m_reg == 0 && m_line == VIS - 1 && m_h == HT - 1));
        start_addr = AW'(value);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_ni = 1'b1;
        // Directed: write collides with entry tick (R6), top address wraps on first advance (R8)
        write_on_entry(SCR - 1);
        write_on_entry(0);
        write_on_entry(7);
        write_on_entry(10);
        // Random writes at arbitrary times, including mid-picture (R6 ignore check via model)
        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            if (($urandom % 40) == 0) start_addr = AW'($urandom % SCR);
        end
        finish_run();
    end

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule